// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the command side of one NOR flash bank behind a synchronous host bus. The host issues single-cycle write strobes carrying an address and a data word. The block recognises the two-write unlock prefix and the commands that may follow it: a single word program, entry to a fast programming mode that skips the unlock prefix, and entry to an identification read mode. A write of the reset code leaves any mode and returns the bank to plain array reads.

A program write starts an internal busy period whose length is a parameter counted in clock cycles. During that period every host write is ignored. Reads return a status word instead of array data. The addressed word is updated only at the end of the busy period, and an update can only clear bits, because the stored word becomes the old word ANDed with the written data. A synchronous hardware reset aborts a running program and erases the small internal array to all ones.

Top module: `nfc_seq`

## Requirements
- R1: The writes AAh at word address 555h, 55h at 2AAh and A0h at 555h, followed by one write of any address and data, start a program operation, and `busy` is high in the cycle after that last write. Command codes are decoded from wdata[7:0].
- R2: `busy` stays high for exactly BUSY_CYCLES clock cycles. After that the bank returns to the mode it programmed from and the addressed word holds its new value.
- R3: Programming stores old AND written data, so a bit at 0 never returns to 1 through programming.
- R4: Every write made while `busy` is high is ignored. It does not lengthen the operation, does not change the stored data and does not begin a command sequence.
- R5: A high `rst` at a clock edge clears `busy` and `rdata`, selects read mode, sets every array word to FFFFh and drops any running program without storing it.
- R6: A read while busy returns bit 7 as the inverse of bit 7 of the data being programmed, and bit 6 as 0 on the first read of the operation, flipping on each further read. All other bits read 0.
- R7: Unlock followed by 20h at 555h enters the fast mode. In that mode A0h at any address followed by an address/data write programs the word, and the bank returns to the fast mode afterwards. A non-A0h write other than F0h is ignored there.
- R8: Unlock followed by 90h at 555h enters ID mode. There addr[7:0] selects the word: 00h gives 0001h, 01h gives 227Eh, 0Eh gives 2222h, 0Fh gives 2200h, and 03h gives 0043h when FAST_HS is 1 or 0042h when it is 0. Any other offset except 02h gives 0000h.
- R9: In ID mode, offset 02h returns 0001h when LOCK_MASK has the bit set for the sector addr[10:9] and 0000h when it is clear. Writes other than F0h leave ID mode unchanged.
- R10: Outside the fast mode, a write that is not the expected next step of the unlock sequence returns the bank to read mode, and nothing is programmed.
- R11: A write with wdata[7:0]=F0h at any address returns the bank to read mode from the unlock steps, ID mode and the fast mode. The exception is a write taken as program data.
- R12: `rdata` is registered. It updates one cycle after a cycle with `rd_en` high and holds its value otherwise. Outside ID mode and busy, a read returns the array word at addr[ARR_AW-1:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One-cycle write strobe for a bus write |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 11 | Word address |
| wdata | input | 16 | Write data; commands in bits 7:0 |
| rdata | output | 16 | Registered read data, ID word or status |
| busy | output | 1 | High while a program operation runs |

## Verification
A wrong sequencer state shows up at the ports at the next read. That read returns an ID word where array data was due, or array data where status was due, or a later read shows an unexpected program result. An off-by-one in the busy timer moves the fall of `busy` by a cycle, and the bench checks that edge exactly. A status bit that fails to toggle or invert is visible on the second read of a busy period. Writes that leak through while busy show up as changed contents once the operation ends.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int AW = 11;
    localparam int DW = 16;

    localparam logic [AW-1:0] ADR_KEY_A = 11'h555;
    localparam logic [AW-1:0] ADR_KEY_B = 11'h2AA;

    localparam logic [7:0] CMD_KEY_A = 8'hAA;
    localparam logic [7:0] CMD_KEY_B = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_FAST  = 8'h20;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    localparam logic [DW-1:0] ID_MFR  = 16'h0001;
    localparam logic [DW-1:0] ID_DEV1 = 16'h227E;
    localparam logic [DW-1:0] ID_DEV2 = 16'h2222;
    localparam logic [DW-1:0] ID_DEV3 = 16'h2200;

    localparam logic [7:0] HS_REDUCED  = 8'h43;
    localparam logic [7:0] HS_STANDARD = 8'h42;

    typedef enum logic [2:0] {
        S_READ,
        S_KEY1,
        S_KEY2,
        S_PROG,
        S_IDENT,
        S_FAST,
        S_FAST_PROG,
        S_BUSY
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } rd_mode_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_wr_t;

    function automatic logic is_cmd(bus_wr_t w, logic [7:0] code, logic [AW-1:0] a);
        return (w.data[7:0] == code) && (w.addr == a);
    endfunction

    function automatic logic [DW-1:0] ident_word(logic [7:0] ofs, logic locked,
                                                 logic [7:0] hs);
        logic [DW-1:0] w;
        case (ofs)
            8'h00:   w = ID_MFR;
            8'h01:   w = ID_DEV1;
            8'h02:   w = {{(DW-1){1'b0}}, locked};
            8'h03:   w = {{(DW-8){1'b0}}, hs};
            8'h0E:   w = ID_DEV2;
            8'h0F:   w = ID_DEV3;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic [DW-1:0] status_word(logic d7, logic tog);
        logic [DW-1:0] w;
        w    = '0;
        w[7] = ~d7;
        w[6] = tog;
        return w;
    endfunction

endpackage

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  bus_wr_t    wr,
    input  logic       done,
    output seq_state_t state,
    output logic       start,
    output bus_wr_t    prog_req
);

    seq_state_t nxt;
    logic       ret_fast;
    logic       is_reset;

    assign is_reset = (wr.data[7:0] == CMD_RESET);

    always_comb begin
        nxt   = state;
        start = 1'b0;
        if (wr_en) begin
            unique case (state)
                S_READ: begin
                    if (is_cmd(wr, CMD_KEY_A, ADR_KEY_A)) nxt = S_KEY1;
                end
                S_KEY1: begin
                    nxt = is_cmd(wr, CMD_KEY_B, ADR_KEY_B) ? S_KEY2 : S_READ;
                end
                S_KEY2: begin
                    if (is_cmd(wr, CMD_PROG, ADR_KEY_A))       nxt = S_PROG;
                    else if (is_cmd(wr, CMD_IDENT, ADR_KEY_A)) nxt = S_IDENT;
                    else if (is_cmd(wr, CMD_FAST, ADR_KEY_A))  nxt = S_FAST;
                    else                                       nxt = S_READ;
                end
                S_PROG, S_FAST_PROG: begin
                    nxt   = S_BUSY;
                    start = 1'b1;
                end
                S_IDENT: begin
                    if (is_reset) nxt = S_READ;
                end
                S_FAST: begin
                    if (is_reset)                         nxt = S_READ;
                    else if (wr.data[7:0] == CMD_PROG)    nxt = S_FAST_PROG;
                end
                S_BUSY: begin
                    nxt = S_BUSY;
                end
                default: nxt = S_READ;
            endcase
        end
        if (state == S_BUSY && done) nxt = ret_fast ? S_FAST : S_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_READ;
            ret_fast <= 1'b0;
            prog_req <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                prog_req <= wr;
                ret_fast <= (state == S_FAST_PROG);
            end
        end
    end

endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign active = (cnt != '0);
    assign done   = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

endmodule

// File: rtl/nfc_array.sv
module nfc_array
    import nfc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_word
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    assign rd_word = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            mem[wr_idx] <= mem[wr_idx] & wr_data;
        end
    end

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int                      BUSY_CYCLES = 8,
    parameter int                      ARR_AW      = 4,
    parameter int                      SECT_W      = 2,
    parameter logic [(1<<SECT_W)-1:0]  LOCK_MASK   = '0,
    parameter bit                      FAST_HS     = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [10:0]   addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic          busy
);

    localparam int SECT_LSB = AW - SECT_W;

    bus_wr_t     wr_bus;
    bus_wr_t     prog_req;
    seq_state_t  seq_st;
    rd_mode_t    rd_mode;
    logic        start;
    logic        done;
    logic        tmr_busy;
    logic        tog;
    logic        locked;
    logic [7:0]  hs_code;
    logic [DW-1:0] arr_word;
    logic [DW-1:0] rd_next;

    assign wr_bus = '{addr: addr, data: wdata};
    assign busy   = tmr_busy;

    nfc_cmd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr       (wr_bus),
        .done     (done),
        .state    (seq_st),
        .start    (start),
        .prog_req (prog_req)
    );

    nfc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .active (tmr_busy),
        .done   (done)
    );

    nfc_array #(.IDX_W(ARR_AW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .wr_idx  (prog_req.addr[ARR_AW-1:0]),
        .wr_data (prog_req.data),
        .rd_idx  (addr[ARR_AW-1:0]),
        .rd_word (arr_word)
    );

    generate
        if (FAST_HS) begin : g_hs_fast
            assign hs_code = HS_REDUCED;
        end else begin : g_hs_std
            assign hs_code = HS_STANDARD;
        end
    endgenerate

    assign locked = LOCK_MASK[addr[AW-1:SECT_LSB]];

    always_comb begin
        if (seq_st == S_BUSY)       rd_mode = RM_STATUS;
        else if (seq_st == S_IDENT) rd_mode = RM_IDENT;
        else                        rd_mode = RM_ARRAY;
    end

    always_comb begin
        unique case (rd_mode)
            RM_STATUS: rd_next = status_word(prog_req.data[7], tog);
            RM_IDENT:  rd_next = ident_word(addr[7:0], locked, hs_code);
            default:   rd_next = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else begin
            if (start)                           tog <= 1'b0;
            else if (rd_en && seq_st == S_BUSY)  tog <= ~tog;
            if (rd_en) rdata <= rd_next;
        end
    end

endmodule

// File: rtl/nfc_seq_chk.sv
module nfc_seq_chk
    import nfc_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [15:0]   wdata,
    input logic [15:0]   rdata,
    input logic          busy,
    input seq_state_t    fsm_state
);

    int   busy_run;
    logic last_w7;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= 0;
            last_w7  <= 1'b0;
        end else begin
            busy_run <= busy ? busy_run + 1 : 0;
            if (wr_en && !busy) last_w7 <= wdata[7];
        end
    end

    // R2: busy lasts exactly BUSY_CYCLES cycles when not cut by reset
    a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (busy_run == BUSY_CYCLES));

    // R2: timer and sequencer agree on the busy phase
    a_r2_timer_fsm_agree: assert property (@(posedge clk) disable iff (rst)
        busy == (fsm_state == S_BUSY));

    // R5: reset clears busy and read data
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && rdata == 16'h0000));

    // R6: DQ7 inverts the programmed bit 7
    a_r6_dq7_inverted: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |=> (rdata[7] == ~last_w7));

    // R6: other status bits are zero
    a_r6_status_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |=> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

    // R6: DQ6 flips between consecutive busy reads
    a_r6_dq6_toggles: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) ##1 (busy && rd_en) |=> (rdata[6] != $past(rdata[6])));

    // R12: read data holds without a read strobe
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind nfc_seq nfc_seq_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .busy      (busy),
    .fsm_state (seq_st)
);

// File: tb/nfc_seq_test.sv
module nfc_seq_test;

    localparam int BC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    nfc_seq #(
        .BUSY_CYCLES (BC),
        .LOCK_MASK   (4'b0100),
        .FAST_HS     (1'b1)
    ) uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [10:0] a, logic [15:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [10:0] a, logic [15:0] exp, string tag);
        addr  = a;
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(11'h555, 16'h00AA);
        wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog(logic [10:0] a, logic [15:0] d);
        unlock();
        wr(11'h555, 16'h00A0);
        wr(a, d);
    endtask

    // monitor: pops the scoreboard for each read strobe
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = rd_en;
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL scoreboard empty actual=%h expected=none", rdata);
                end else begin
                    chk(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        chk("R5 busy after reset", {15'b0, busy}, 16'h0000);
        chk("R5 rdata after reset", rdata, 16'h0000);
        rd(11'h003, 16'hFFFF, "R5 erased word");

        // standard program with status reads and ignored writes
        prog(11'h003, 16'h1234);
        chk("R1 busy starts", {15'b0, busy}, 16'h0001);
        rd(11'h003, 16'h0080, "R6 first status read");
        rd(11'h003, 16'h00C0, "R6 second status read");
        wr(11'h555, 16'h00AA);
        wr(11'h123, 16'h00F0);
        tick(1);
        chk("R2 busy in last cycle", {15'b0, busy}, 16'h0001);
        tick(1);
        chk("R2 busy ends", {15'b0, busy}, 16'h0000);
        rd(11'h003, 16'h1234, "R2 programmed word");
        wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'h003, 16'h0000);
        chk("R4 no program from busy writes", {15'b0, busy}, 16'h0000);
        rd(11'h003, 16'h1234, "R4 word unchanged");

        // AND semantics
        prog(11'h003, 16'hFF0F);
        tick(BC);
        rd(11'h003, 16'h1204, "R3 bits only clear");

        // broken sequences
        wr(11'h555, 16'h00AA);
        wr(11'h2AB, 16'h0055);
        wr(11'h555, 16'h00A0);
        wr(11'h005, 16'h0000);
        chk("R10 bad second step", {15'b0, busy}, 16'h0000);
        rd(11'h005, 16'hFFFF, "R10 nothing programmed");
        unlock();
        wr(11'h555, 16'h0077);
        wr(11'h555, 16'h00A0);
        wr(11'h005, 16'h0000);
        rd(11'h005, 16'hFFFF, "R10 bad third step");

        // fast mode
        unlock();
        wr(11'h555, 16'h0020);
        wr(11'h000, 16'h00A0);
        wr(11'h006, 16'h00FF);
        chk("R7 fast program busy", {15'b0, busy}, 16'h0001);
        tick(BC);
        rd(11'h006, 16'h00FF, "R7 fast program word");
        wr(11'h123, 16'h00A0);
        wr(11'h007, 16'h0F0F);
        tick(BC);
        rd(11'h007, 16'h0F0F, "R7 repeated fast program");
        wr(11'h008, 16'h1111);
        chk("R7 stray write ignored", {15'b0, busy}, 16'h0000);
        rd(11'h008, 16'hFFFF, "R7 stray write no store");
        wr(11'h008, 16'h00F0);
        wr(11'h000, 16'h00A0);
        wr(11'h009, 16'h0000);
        rd(11'h009, 16'hFFFF, "R11 reset leaves fast mode");

        // ID mode
        unlock();
        wr(11'h555, 16'h0090);
        rd(11'h000, 16'h0001, "R8 maker word");
        rd(11'h001, 16'h227E, "R8 device word 1");
        rd(11'h00E, 16'h2222, "R8 device word 2");
        rd(11'h00F, 16'h2200, "R8 device word 3");
        rd(11'h003, 16'h0043, "R8 handshake code");
        rd(11'h005, 16'h0000, "R8 other offset");
        rd(11'h402, 16'h0001, "R9 locked sector");
        rd(11'h602, 16'h0000, "R9 unlocked sector");
        rd(11'h002, 16'h0000, "R9 sector zero");
        wr(11'h000, 16'h1234);
        rd(11'h000, 16'h0001, "R9 write ignored in ID mode");
        wr(11'h7FF, 16'h00F0);
        rd(11'h003, 16'h1204, "R11 reset leaves ID mode");

        // hardware reset aborts a program
        prog(11'h00A, 16'h0000);
        tick(2);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R5 reset stops busy", {15'b0, busy}, 16'h0000);
        chk("R5 reset clears rdata", rdata, 16'h0000);
        rd(11'h00A, 16'hFFFF, "R5 aborted word not stored");
        rd(11'h003, 16'hFFFF, "R5 array erased");
        prog(11'h00A, 16'h0F00);
        tick(BC);
        rd(11'h00A, 16'h0F00, "R1 program after reset");
        tick(2);
        chk("R12 rdata holds", rdata, 16'h0F00);

        tick(3);
        chk("scoreboard drained", 16'(exp_q.size()), 16'h0000);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule